// File: doc/BRIEF.md
# Serial HDLC Frame Sender with Byte Queue

This block turns messages that a host writes one byte at a time into a bit-serial HDLC stream for a slow data link inside a framer. The bytes go into a byte queue of parameterised depth (64 by default). Each byte is tagged by the host when it is the final byte of its message. The serial side wraps every message in opening and closing flags. It inserts zero bits so the payload can never look like a flag, and it appends a 16-bit frame check sequence. When no message is waiting, it sends flag octets without a break.

The link owner paces the stream with a bit-enable input. A bit is consumed on each rising clock edge where the enable is high, and it is held otherwise. The host reads queue level flags to decide when it may write. Two sticky event flags record a completed message and a starved frame, and a single interrupt line combines the enabled conditions.

If the queue runs dry before the tagged byte arrives, the sender abandons the frame with a run of ones and then returns to flags.

Top module: `hdlc_tx_core`

## Requirements
- R1: With no queued byte, `tx_bit` carries back-to-back flag octets 0x7E, least significant bit first (0,1,1,1,1,1,1,0). The value at reset is the first bit of a flag.
- R2: The queue holds 64 bytes. `fifo_full` is 1 exactly when 64 bytes are stored, and a write while `fifo_full` is 1 is dropped.
- R3: `fifo_empty` is 1 exactly when no byte is stored.
- R4: `fifo_half` is 1 when 32 or fewer bytes are stored.
- R5: A message is sent as opening flag, payload bytes in write order each LSB first, two FCS bytes, then a closing flag. The closing flag may serve as the next frame's opening flag.
- R6: Inside payload and FCS, a 0 is inserted after every run of five 1s. Flags are never stuffed.
- R7: The FCS is the ones complement of a CRC-16 over the payload (x^16+x^12+x^5+1, reflected form 0x8408, preset 0xFFFF). It is sent low byte first. A CRC over payload plus FCS leaves the residue 0xF0B8.
- R8: `evt_msg_done` becomes 1 after the closing flag of a tagged message has been sent.
- R9: If the queue is empty when an untagged payload byte finishes, the sender emits eight 1s, sets `evt_underrun`, then returns to flags and can send later frames.
- R10: Both event flags stay set until a cycle with `evt_rd` high, and read 0 after it. A new event in the read cycle wins.
- R11: `irq` is the OR of the enabled conditions: `irq_en[0]` with `fifo_half`, `irq_en[1]` with not full, `irq_en[2]` with `evt_msg_done`, and `irq_en[3]` with `evt_underrun`.
- R12: While `bit_en` is 0, `tx_bit` and the serial state hold, so gapped pacing yields the same frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host byte write strobe |
| wr_data | input | 8 | Byte to queue |
| wr_last | input | 1 | Tags the byte as the final one of its message |
| bit_en | input | 1 | Link takes `tx_bit` on this edge |
| tx_bit | output | 1 | Serial output bit |
| evt_rd | input | 1 | Host read of the event flags; clears them |
| irq_en | input | 4 | Interrupt enables (half, not full, done, underrun) |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| fifo_half | output | 1 | Queue at most half full |
| evt_msg_done | output | 1 | Sticky message-sent flag |
| evt_underrun | output | 1 | Sticky underrun flag |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest states to reach from the ports are a full queue with the serial side frozen, and a frame starved mid-payload. To reach the full queue, the bench holds `bit_en` low so nothing drains, fills all 64 entries, and offers one extra write. Reaching the starved frame takes an untagged short message. A bench-side bit decoder strips the stuffing, detects flags and aborts, and checks the residue. Payloads of all ones and of flag-like bytes force stuffing at byte and FCS boundaries.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [1:0] {M_FLAG, M_DATA, M_FCS, M_ABORT} tx_mode_e;

  localparam logic [7:0]  FLAG_OCTET  = 8'h7E;
  localparam logic [7:0]  ABORT_OCTET = 8'hFF;
  localparam logic [15:0] CRC_POLY_R  = 16'h8408;
  localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
  localparam int unsigned STUFF_RUN   = 5;

  // one LSB-first step of the reflected CRC-16
  function automatic logic [15:0] crc_bit(input logic [15:0] c, input logic b);
    logic [15:0] s;
    s = {1'b0, c[15:1]};
    if (c[0] ^ b) s = s ^ CRC_POLY_R;
    return s;
  endfunction
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned WIDTH = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full,
  output logic             half
);
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW   = $clog2(DEPTH + 1);
  localparam int unsigned HALF = DEPTH / 2;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_n, rptr_q, rptr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic push_ok, pop_ok;

  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign half     = (cnt_q <= CW'(HALF));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign pop_data = mem[rptr_q];

  always_comb begin
    wptr_n = wptr_q;
    rptr_n = rptr_q;
    cnt_n  = cnt_q;
    if (push_ok) wptr_n = (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + AW'(1);
    if (pop_ok)  rptr_n = (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + AW'(1);
    if (push_ok && !pop_ok)      cnt_n = cnt_q + CW'(1);
    else if (pop_ok && !push_ok) cnt_n = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_n;
      rptr_q <= rptr_n;
      cnt_q  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> $stable(cnt_q)); // R2
  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !half); // R4
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [7:0] q_data,
  input  logic       q_last,
  input  logic       q_empty,
  output logic       q_pop,
  output logic       tx_bit,
  output logic       done_pulse,
  output logic       udr_pulse
);
  tx_mode_e    mode_q, mode_n;
  logic [7:0]  sh_q, sh_n;
  logic [2:0]  bcnt_q, bcnt_n;
  logic [2:0]  ones_q, ones_n;
  logic        stuff_q, stuff_n;
  logic [15:0] crc_q, crc_n, crc_step;
  logic        last_q, last_n;
  logic        fcs_hi_q, fcs_hi_n;
  logic        close_q, close_n;
  logic        stuffable, octet_end;

  assign tx_bit    = stuff_q ? 1'b0 : sh_q[0];
  assign stuffable = (mode_q == M_DATA) || (mode_q == M_FCS);
  assign octet_end = (bcnt_q == 3'd7);
  assign crc_step  = crc_bit(crc_q, sh_q[0]);

  always_comb begin
    mode_n     = mode_q;
    sh_n       = sh_q;
    bcnt_n     = bcnt_q;
    ones_n     = ones_q;
    stuff_n    = stuff_q;
    crc_n      = crc_q;
    last_n     = last_q;
    fcs_hi_n   = fcs_hi_q;
    close_n    = close_q;
    q_pop      = 1'b0;
    done_pulse = 1'b0;
    udr_pulse  = 1'b0;
    if (bit_en) begin
      if (stuff_q) begin
        stuff_n = 1'b0;
        ones_n  = '0;
      end else begin
        sh_n   = {1'b0, sh_q[7:1]};
        bcnt_n = bcnt_q + 3'd1;
        if (stuffable) begin
          if (sh_q[0]) begin
            ones_n = ones_q + 3'd1;
            if (ones_q == 3'(STUFF_RUN - 1)) stuff_n = 1'b1;
          end else begin
            ones_n = '0;
          end
        end
        if (mode_q == M_DATA) crc_n = crc_step;
        if (octet_end) begin
          unique case (mode_q)
            M_FLAG, M_ABORT: begin
              if (mode_q == M_FLAG && close_q) begin
                done_pulse = 1'b1;
                close_n    = 1'b0;
              end
              if (mode_q == M_FLAG && !q_empty) begin
                mode_n = M_DATA;
                sh_n   = q_data;
                last_n = q_last;
                q_pop  = 1'b1;
                crc_n  = CRC_PRESET;
                ones_n = '0;
              end else begin
                mode_n = M_FLAG;
                sh_n   = FLAG_OCTET;
              end
            end
            M_DATA: begin
              if (last_q) begin
                mode_n   = M_FCS;
                sh_n     = ~crc_step[7:0];
                fcs_hi_n = 1'b0;
              end else if (!q_empty) begin
                sh_n   = q_data;
                last_n = q_last;
                q_pop  = 1'b1;
              end else begin
                mode_n    = M_ABORT;
                sh_n      = ABORT_OCTET;
                ones_n    = '0;
                udr_pulse = 1'b1;
              end
            end
            default: begin
              if (!fcs_hi_q) begin
                sh_n     = ~crc_q[15:8];
                fcs_hi_n = 1'b1;
              end else begin
                mode_n   = M_FLAG;
                sh_n     = FLAG_OCTET;
                fcs_hi_n = 1'b0;
                close_n  = 1'b1;
                ones_n   = '0;
              end
            end
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= M_FLAG;
      sh_q     <= FLAG_OCTET;
      bcnt_q   <= '0;
      ones_q   <= '0;
      stuff_q  <= 1'b0;
      crc_q    <= CRC_PRESET;
      last_q   <= 1'b0;
      fcs_hi_q <= 1'b0;
      close_q  <= 1'b0;
    end else if (bit_en) begin
      mode_q   <= mode_n;
      sh_q     <= sh_n;
      bcnt_q   <= bcnt_n;
      ones_q   <= ones_n;
      stuff_q  <= stuff_n;
      crc_q    <= crc_n;
      last_q   <= last_n;
      fcs_hi_q <= fcs_hi_n;
      close_q  <= close_n;
    end
  end

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit)); // R12
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stuffable |-> (ones_q <= 3'(STUFF_RUN))); // R6
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop |-> !q_empty); // R9
endmodule

// File: rtl/hdlc_tx_events.sv
module hdlc_tx_events (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_done,
  input  logic       set_udr,
  input  logic       evt_rd,
  input  logic [3:0] irq_en,
  input  logic       lvl_half,
  input  logic       lvl_full,
  output logic       done_flag,
  output logic       udr_flag,
  output logic       irq
);
  logic done_q, done_n, udr_q, udr_n;

  always_comb begin
    done_n = set_done | (done_q & ~evt_rd);
    udr_n  = set_udr  | (udr_q  & ~evt_rd);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      done_q <= done_n;
      udr_q  <= udr_n;
    end
  end

  assign done_flag = done_q;
  assign udr_flag  = udr_q;
  assign irq = (irq_en[0] & lvl_half) | (irq_en[1] & ~lvl_full) |
               (irq_en[2] & done_q)   | (irq_en[3] & udr_q);

  AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd && !set_done) |=> !done_q); // R10
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_done, set_udr})); // R8
endmodule

// File: rtl/hdlc_tx_core.sv
module hdlc_tx_core #(
  parameter int unsigned FIFO_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wr_last,
  input  logic       bit_en,
  output logic       tx_bit,
  input  logic       evt_rd,
  input  logic [3:0] irq_en,
  output logic       fifo_empty,
  output logic       fifo_full,
  output logic       fifo_half,
  output logic       evt_msg_done,
  output logic       evt_underrun,
  output logic       irq
);
  localparam int unsigned ENTRY_W = 9;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic [ENTRY_W-1:0] q_entry;
  logic q_pop, done_pulse, udr_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_int_n),
    .push(wr_en), .push_data({wr_last, wr_data}),
    .pop(q_pop), .pop_data(q_entry),
    .empty(fifo_empty), .full(fifo_full), .half(fifo_half)
  );

  hdlc_tx_serializer u_ser (
    .clk(clk), .rst_n(rst_int_n), .bit_en(bit_en),
    .q_data(q_entry[7:0]), .q_last(q_entry[8]), .q_empty(fifo_empty),
    .q_pop(q_pop), .tx_bit(tx_bit),
    .done_pulse(done_pulse), .udr_pulse(udr_pulse)
  );

  hdlc_tx_events u_evt (
    .clk(clk), .rst_n(rst_int_n),
    .set_done(done_pulse), .set_udr(udr_pulse), .evt_rd(evt_rd),
    .irq_en(irq_en), .lvl_half(fifo_half), .lvl_full(fifo_full),
    .done_flag(evt_msg_done), .udr_flag(evt_underrun), .irq(irq)
  );

  AST_UDR_ONLY_NONEMPTY_EMPTY: assert property (@(posedge clk) disable iff (!rst_int_n)
    udr_pulse |-> fifo_empty); // R9
endmodule

// File: tb/hdlc_tx_core_tb_top.sv
module hdlc_tx_core_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_last = 1'b0, bit_en = 1'b0, evt_rd = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] irq_en = 4'h0;
  logic tx_bit, fifo_empty, fifo_full, fifo_half, evt_msg_done, evt_underrun, irq;

  always #5 clk = ~clk;

  hdlc_tx_core dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_last(wr_last),
    .bit_en(bit_en), .tx_bit(tx_bit), .evt_rd(evt_rd), .irq_en(irq_en),
    .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_half(fifo_half),
    .evt_msg_done(evt_msg_done), .evt_underrun(evt_underrun), .irq(irq)
  );

  int checks = 0, errors = 0;
  int en_mode = 0;
  int cyc = 0;

  // messages: {length, first byte, step}
  localparam logic [23:0] MSGS [5] = '{
    {8'd1,  8'h00, 8'h00},
    {8'd3,  8'hFF, 8'h00},
    {8'd9,  8'h31, 8'h01},
    {8'd20, 8'h7E, 8'h11},
    {8'd40, 8'h05, 8'h3B}
  };

  // bench-side HDLC receiver
  int ones_run = 0, nb = 0, frames_seen = 0, aborts_seen = 0, got_n = 0, raw_n = 0;
  bit in_frame = 1'b0;
  bit fbits [1024];
  logic [7:0] got [128];
  bit raw0 [16];
  logic [7:0] exp_b [80];
  int exp_n = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_frame();
    got_n = (nb % 8 == 0) ? nb / 8 : -1;
    for (int k = 0; k < nb / 8 && k < 128; k++) begin
      for (int j = 0; j < 8; j++) got[k][j] = fbits[k*8 + j];
    end
    frames_seen++;
  endtask

  task automatic take_bit(input bit b);
    if (raw_n < 16) raw0[raw_n] = b;
    raw_n++;
    if (b) begin
      ones_run++;
      if (in_frame && nb < 1024) begin fbits[nb] = 1'b1; nb++; end
      if (ones_run == 7) begin
        if (in_frame) aborts_seen++;
        in_frame = 1'b0;
      end
    end else begin
      if (ones_run == 6) begin
        if (in_frame && nb >= 7) begin
          nb -= 7;
          if (nb > 0) finish_frame();
        end
        in_frame = 1'b1;
        nb = 0;
      end else if (ones_run < 5) begin
        if (in_frame && nb < 1024) begin fbits[nb] = 1'b0; nb++; end
      end
      ones_run = 0;
    end
  endtask

  initial forever begin
    @(negedge clk);
    if (bit_en && rst_n) take_bit(tx_bit);
  end

  initial forever begin
    @(posedge clk);
    #1;
    cyc++;
    bit_en = (en_mode == 1) ? 1'b1 : (en_mode == 2) ? (cyc % 3 == 0) : 1'b0;
  end

  function automatic logic [15:0] residue(int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++)
      for (int j = 0; j < 8; j++)
        c = (c[0] ^ got[k][j]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
    return c;
  endfunction

  task automatic wr_byte(input logic [7:0] d, input logic last, input bit force_wr);
    if (!force_wr) while (fifo_full) @(posedge clk) #1;
    wr_en = 1'b1; wr_data = d; wr_last = last;
    @(posedge clk); #1;
    wr_en = 1'b0; wr_last = 1'b0;
  endtask

  task automatic send_msg(int len, logic [7:0] first, logic [7:0] step);
    exp_n = len;
    for (int k = 0; k < len; k++) begin
      exp_b[k] = first + 8'(k) * step;
      wr_byte(exp_b[k], k == len - 1, 1'b0);
    end
  endtask

  task automatic wait_frame(int prev);
    int t = 0;
    while (frames_seen == prev && t < 20000) begin @(negedge clk); t++; end
  endtask

  task automatic check_frame(string tag);
    int bad = 0;
    chk({tag, " R5 length"}, got_n, exp_n + 2);
    for (int k = 0; k < exp_n && k < 80; k++) if (got[k] != exp_b[k]) bad++;
    chk({tag, " R6 payload bytes"}, bad, 0);
    chk({tag, " R7 residue"}, int'(residue(exp_n + 2)), 16'hF0B8);
  endtask

  task automatic read_events();
    @(posedge clk); #1; evt_rd = 1'b1;
    @(posedge clk); #1; evt_rd = 1'b0;
  endtask

  initial begin
    int prev;
    logic hold;
    #100000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int prev, bad;
    logic hold;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // reset state
    chk("R3 empty at reset", fifo_empty, 1);
    chk("R2 full at reset", fifo_full, 0);
    chk("R4 half at reset", fifo_half, 1);
    chk("R10 events at reset", {evt_msg_done, evt_underrun}, 0);
    chk("R1 first bit at reset", tx_bit, 0);

    // idle flags
    en_mode = 1;
    repeat (80) @(posedge clk);
    #1;
    bad = 0;
    for (int i = 0; i < 16; i++) if (raw0[i] != ((i % 8 != 0) && (i % 8 != 7))) bad++;
    chk("R1 idle flag pattern", bad, 0);
    chk("R1 no frame while idle", frames_seen, 0);

    // table of messages
    for (int m = 0; m < 5; m++) begin
      prev = frames_seen;
      send_msg(int'(MSGS[m][23:16]), MSGS[m][15:8], MSGS[m][7:0]);
      wait_frame(prev);
      check_frame($sformatf("msg%0d", m));
      repeat (3) @(posedge clk);
      #1;
      chk("R8 done flag set", evt_msg_done, 1);
      chk("R9 no underrun", evt_underrun, 0);
      chk("R3 empty after send", fifo_empty, 1);
      irq_en = 4'b0100;
      #1 chk("R11 irq on done", irq, 1);
      irq_en = 4'b0000;
      read_events();
      chk("R10 done cleared by read", evt_msg_done, 0);
    end

    // gapped pacing and hold
    en_mode = 0;
    @(posedge clk); #1;
    bad = 0;
    hold = tx_bit;
    repeat (6) begin @(negedge clk); if (tx_bit != hold) bad++; end
    chk("R12 hold while disabled", bad, 0);
    en_mode = 2;
    prev = frames_seen;
    send_msg(20, 8'hF8, 8'h07);
    wait_frame(prev);
    check_frame("R12 gapped");

    // fill queue with stream stalled
    en_mode = 0;
    repeat (40) @(posedge clk);
    #1;
    exp_n = 64;
    for (int k = 0; k < 64; k++) begin
      exp_b[k] = 8'(k * 5 + 1);
      wr_byte(exp_b[k], k == 63, 1'b0);
      if (k == 31) chk("R4 half at 32", fifo_half, 1);
      if (k == 32) chk("R4 half at 33", fifo_half, 0);
      if (k == 62) chk("R2 not full at 63", fifo_full, 0);
    end
    chk("R2 full at 64", fifo_full, 1);
    irq_en = 4'b0011;
    #1 chk("R11 irq low when full", irq, 0);
    wr_byte(8'hAA, 1'b0, 1'b1);
    chk("R2 still full after extra write", fifo_full, 1);
    prev = frames_seen;
    en_mode = 1;
    wait_frame(prev);
    check_frame("R2 full frame");
    repeat (200) @(posedge clk);
    #1;
    chk("R2 extra write dropped: empty", fifo_empty, 1);
    chk("R2 extra write dropped: no underrun", evt_underrun, 0);
    chk("R11 irq on half", irq, 1);
    irq_en = 4'b0000;
    read_events();

    // underrun
    prev = aborts_seen;
    wr_byte(8'h12, 1'b0, 1'b0);
    wr_byte(8'h34, 1'b0, 1'b0);
    wr_byte(8'h56, 1'b0, 1'b0);
    repeat (150) @(posedge clk);
    #1;
    chk("R9 underrun flag", evt_underrun, 1);
    chk("R9 abort seen on line", aborts_seen - prev, 1);
    irq_en = 4'b1000;
    #1 chk("R11 irq on underrun", irq, 1);
    irq_en = 4'b0000;
    read_events();
    chk("R10 underrun cleared by read", evt_underrun, 0);
    prev = frames_seen;
    send_msg(5, 8'hA0, 8'h01);
    wait_frame(prev);
    check_frame("R9 after abort");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule